// File: doc/BRIEF.md
# Quad-Channel Serial DAC Frame Controller

This block keeps a four-channel, 12-bit serial DAC fed with fresh sample values. Logic elsewhere on the chip presents one 12-bit sample per channel on a flattened bus. At a fixed frame rate the block shifts a 32-bit command word to the DAC over three wires: a divided serial clock, an active-low frame sync and a serial data line. It visits the channels in turn. The very first frame after reset is a one-off setup word that switches on the DAC's internal voltage reference.

A frame word is laid out MSB first as four zero bits, a 4-bit command, a 4-bit address, the 12-bit sample and eight zero bits. In automatic mode the command is "write and update at once" (0011) and the address walks 0, 1, 2, 3. In manual mode an 8-bit input supplies the command and address fields directly. The serial clock idles high. Every change of data or frame sync lines up with a falling serial-clock edge, so the DAC can sample safely on the rising edge.

The serializer is a three-state machine. ST_IDLE moves to ST_SHIFT on a pacing tick: the frame is loaded, sync drops and the first bit goes out. ST_SHIFT stays put for 32 serial-clock periods and then moves to ST_FINISH, where sync rises and done pulses. ST_FINISH always returns to ST_IDLE on the next cycle. A pacing tick that arrives outside ST_IDLE is not acted on.

Top module: `quad_dac_frame_ctrl`

## Requirements
- R1: While reset is held and right after it is released, dac_sclk=1, dac_sync_n=1, dac_sdo=0, busy=0 and done=0.
- R2: The first frame after reset is 0x08000001, which is command 1000, address 0000, data 0 and LSB 1 to enable the internal reference. It is sent exactly once, so the next frame is already a channel frame.
- R3: Each frame carries 32 bits, MSB first. Bits 31:28 are 0, bits 27:24 are the command, bits 23:20 are the address, bits 19:8 are the sample and bits 7:0 are 0. dac_sync_n stays low for exactly 32*CLK_DIV system cycles, which holds exactly 32 rising edges of dac_sclk.
- R4: dac_sdo changes, and dac_sync_n falls, only in a cycle where dac_sclk falls.
- R5: dac_sclk has a period of CLK_DIV system cycles and is low for the first CLK_DIV/2 cycles of each bit. It is high whenever dac_sync_n is high, and dac_sync_n stays high for at least CLK_DIV cycles between frames.
- R6: In automatic mode the frames use command 0011 and addresses 0,1,2,3,0,… in turn. Channel k's sample is sample_in[12k+11:12k].
- R7: The inputs are captured in the cycle dac_sync_n falls. Changing them later in that frame has no effect on the bits being shifted out.
- R8: With manual_en=1 the command is manual_sel[7:4], the address is manual_sel[3:0] and the data is the sample of channel manual_sel[1:0]. The automatic rotation does not advance, so automatic mode resumes with the channel that would have come next.
- R9: Frame starts (falls of dac_sync_n) are exactly FRAME_PERIOD system cycles apart.
- R10: busy is high exactly while dac_sync_n is low. done is high for a single cycle, beginning in the cycle dac_sync_n returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| manual_en | input | 1 | Selects manual frame contents |
| manual_sel | input | 8 | Manual command (7:4) and address (3:0) |
| sample_in | input | 48 | Four 12-bit samples, channel k at bits 12k+11:12k |
| dac_sclk | output | 1 | Serial clock to the DAC, idles high |
| dac_sync_n | output | 1 | Active-low frame sync |
| dac_sdo | output | 1 | Serial data, MSB first |
| busy | output | 1 | High while a frame is on the wire |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The bench decodes each frame at the serial-clock rising edges and watches for a second reference-setup frame. A block that latched its setup flag wrongly would repeat that frame and shift every channel slot along by one. It changes a channel's sample 40 cycles into that channel's frame: a block that shifted live input instead of a latched copy would put the new value on the wire. Manual mode is checked both with the all-channels address and with a single-channel address, and the bench then confirms that automatic mode picks up at the correct channel. A rotation counter that kept running in manual mode would skip a channel. The bench also measures how long sync stays low, the gap between frames, the phase of every clock rise and the timing of each data transition. Any off-by-one in the bit count or the divider, or data that changes on the wrong edge, shows up in those figures.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int FRAME_BITS = 32;
    localparam int SAMPLE_W   = 12;
    localparam int FIELD_W    = 4;

    localparam logic [FIELD_W-1:0] CMD_WR_UPD = 4'b0011;
    localparam logic [FIELD_W-1:0] CMD_REF    = 4'b1000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FINISH
    } ser_state_t;

    function automatic logic [FRAME_BITS-1:0] pack_frame(
        input logic [FIELD_W-1:0]  cmd,
        input logic [FIELD_W-1:0]  addr,
        input logic [SAMPLE_W-1:0] smp,
        input logic [7:0]          tail
    );
        return {4'h0, cmd, addr, smp, tail};
    endfunction

    localparam logic [FRAME_BITS-1:0] REF_FRAME = {4'h0, CMD_REF, 4'h0, 12'h000, 8'h01};

endpackage

// File: rtl/qdac_pacer.sv
module qdac_pacer #(
    parameter int PERIOD = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R9

endmodule

// File: rtl/qdac_frame_builder.sv
module qdac_frame_builder
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         manual_en,
    input  logic [7:0]                   manual_sel,
    input  logic [NUM_CH*SAMPLE_W-1:0]   samples,
    output logic [FRAME_BITS-1:0]        frame
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);

    logic            ref_on;
    logic [CH_W-1:0] chan;
    logic [SAMPLE_W-1:0] smp_auto, smp_man;

    always_comb begin
        smp_auto = samples[int'(chan) * SAMPLE_W +: SAMPLE_W];
        smp_man  = samples[int'(manual_sel[CH_W-1:0]) * SAMPLE_W +: SAMPLE_W];
        if (!ref_on)
            frame = REF_FRAME;
        else if (manual_en)
            frame = pack_frame(manual_sel[7:4], manual_sel[3:0], smp_man, 8'h00);
        else
            frame = pack_frame(CMD_WR_UPD, FIELD_W'(chan), smp_auto, 8'h00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_on <= 1'b0;
            chan   <= '0;
        end else if (load) begin
            if (!ref_on)
                ref_on <= 1'b1;
            else if (!manual_en)
                chan <= (chan == CH_LAST) ? '0 : chan + 1'b1;
        end
    end

    AST_REF_ON_LOAD:    assert property (@(posedge clk) disable iff (!rst_n) $rose(ref_on) |-> $past(load)); // R2
    AST_MANUAL_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n) (load && manual_en && ref_on) |=> $stable(chan)); // R8

endmodule

// File: rtl/qdac_serializer.sv
module qdac_serializer
    import qdac_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  load,
    output logic                  sclk,
    output logic                  sync_n,
    output logic                  sdo,
    output logic                  busy,
    output logic                  done
);
    localparam int HALF    = CLK_DIV / 2;
    localparam int PH_W    = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W   = $clog2(FRAME_BITS);
    localparam int LOW_CYC = FRAME_BITS * CLK_DIV;
    localparam int LO_W    = $clog2(LOW_CYC + 1);
    localparam int HI_W    = $clog2(CLK_DIV + 1);

    ser_state_t state, nxt;
    logic [PH_W-1:0]       ph;
    logic [BIT_W-1:0]      bitcnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  last_ph, last_bit;

    assign load     = (state == ST_IDLE) && tick;
    assign last_ph  = (ph == PH_W'(CLK_DIV - 1));
    assign last_bit = (bitcnt == BIT_W'(FRAME_BITS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (tick) nxt = ST_SHIFT;
            ST_SHIFT:  if (last_ph && last_bit) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk   <= 1'b1;
            sync_n <= 1'b1;
            sdo    <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            ph     <= '0;
            bitcnt <= '0;
            shreg  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tick) begin
                        shreg  <= {frame[FRAME_BITS-2:0], 1'b0};
                        sdo    <= frame[FRAME_BITS-1];
                        sclk   <= 1'b0;
                        sync_n <= 1'b0;
                        busy   <= 1'b1;
                        ph     <= '0;
                        bitcnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    ph <= last_ph ? '0 : ph + 1'b1;
                    if (ph == PH_W'(HALF - 1))
                        sclk <= 1'b1;
                    if (last_ph) begin
                        if (last_bit) begin
                            sync_n <= 1'b1;
                            busy   <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            sclk   <= 1'b0;
                            sdo    <= shreg[FRAME_BITS-1];
                            shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Cycle counters that watch the line timing from outside the state machine.
    logic [LO_W-1:0] lo_cnt;
    logic [HI_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= sync_n ? '0 : lo_cnt + 1'b1;
            if (!sync_n)                    hi_cnt <= '0;
            else if (hi_cnt < HI_W'(CLK_DIV)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_SYNC_LOW_LEN:   assert property (@(posedge clk) disable iff (!rst_n) $rose(sync_n) |-> (lo_cnt == LO_W'(LOW_CYC))); // R3
    AST_SDO_ON_FALL:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(sdo) |-> $fell(sclk)); // R4
    AST_SYNC_ON_FALL:   assert property (@(posedge clk) disable iff (!rst_n) $fell(sync_n) |-> $fell(sclk)); // R4
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) sync_n |-> sclk); // R5
    AST_GAP_MIN:        assert property (@(posedge clk) disable iff (!rst_n) $fell(sync_n) |-> (hi_cnt >= HI_W'(CLK_DIV))); // R5
    AST_BUSY_MATCH:     assert property (@(posedge clk) disable iff (!rst_n) busy == !sync_n); // R10
    AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10

endmodule

// File: rtl/quad_dac_frame_ctrl.sv
module quad_dac_frame_ctrl
    import qdac_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int FRAME_PERIOD = 10000,
    parameter int NUM_CH       = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       manual_en,
    input  logic [7:0]                 manual_sel,
    input  logic [NUM_CH*SAMPLE_W-1:0] sample_in,
    output logic                       dac_sclk,
    output logic                       dac_sync_n,
    output logic                       dac_sdo,
    output logic                       busy,
    output logic                       done
);
    logic tick, load;
    logic [FRAME_BITS-1:0] frame;

    initial begin
        AST_DIV_EVEN:   assert (CLK_DIV >= 2 && CLK_DIV % 2 == 0); // R5
        AST_PERIOD_FIT: assert (FRAME_PERIOD > (FRAME_BITS + 1) * CLK_DIV + 1); // R9
    end

    qdac_pacer #(.PERIOD(FRAME_PERIOD)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    qdac_frame_builder #(.NUM_CH(NUM_CH)) u_builder (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .manual_en  (manual_en),
        .manual_sel (manual_sel),
        .samples    (sample_in),
        .frame      (frame)
    );

    qdac_serializer #(.CLK_DIV(CLK_DIV)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .frame  (frame),
        .load   (load),
        .sclk   (dac_sclk),
        .sync_n (dac_sync_n),
        .sdo    (dac_sdo),
        .busy   (busy),
        .done   (done)
    );

endmodule

// File: tb/quad_dac_frame_ctrl_test.sv
module quad_dac_frame_ctrl_test;

    localparam int DIV    = 4;
    localparam int HALF   = DIV / 2;
    localparam int PERIOD = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        manual_en = 1'b0;
    logic [7:0]  manual_sel = 8'h00;
    logic [47:0] sample_in = '0;
    logic        dac_sclk, dac_sync_n, dac_sdo, busy, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_fall = 0;
    bit have_prev = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    quad_dac_frame_ctrl #(.CLK_DIV(DIV), .FRAME_PERIOD(PERIOD), .NUM_CH(4)) uut (
        .clk(clk), .rst_n(rst_n), .manual_en(manual_en), .manual_sel(manual_sel),
        .sample_in(sample_in), .dac_sclk(dac_sclk), .dac_sync_n(dac_sync_n),
        .dac_sdo(dac_sdo), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] chan_frame(input logic [3:0] cmd, input logic [3:0] addr, input logic [11:0] smp);
        return {4'h0, cmd, addr, smp, 8'h00};
    endfunction

    function automatic logic [11:0] smp(input int ch);
        return sample_in[ch*12 +: 12];
    endfunction

    // R4: data and sync transitions line up with falling serial clock
    logic m_sclk, m_sdo, m_sync;
    bit   m_valid = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
        end else begin
            if (m_valid && dac_sdo !== m_sdo) begin
                checks++;
                if (!(m_sclk === 1'b1 && dac_sclk === 1'b0)) begin
                    errors++;
                    $display("FAIL R4 sdo changed with sclk %b->%b, expected 1->0", m_sclk, dac_sclk);
                end
            end
            if (m_valid && m_sync === 1'b1 && dac_sync_n === 1'b0) begin
                checks++;
                if (!(m_sclk === 1'b1 && dac_sclk === 1'b0)) begin
                    errors++;
                    $display("FAIL R4 sync fell with sclk %b->%b, expected 1->0", m_sclk, dac_sclk);
                end
            end
            m_sclk = dac_sclk; m_sdo = dac_sdo; m_sync = dac_sync_n; m_valid = 1;
        end
    end

    task automatic capture(output logic [31:0] f);
        int lowc, nb, gap, fall_cyc;
        logic prev;
        bit idle_ok, period_ok;
        idle_ok = 1; gap = 0;
        while (dac_sync_n !== 1'b0) begin
            if (dac_sclk !== 1'b1) idle_ok = 0;
            gap++;
            @(negedge clk);
        end
        fall_cyc = cyc;
        chk("R10 busy at sync fall", 32'(busy), 32'd1);
        f = '0; nb = 0; lowc = 1; prev = dac_sclk;
        period_ok = (dac_sclk === 1'b0);
        forever begin
            @(negedge clk);
            if (dac_sync_n === 1'b1) break;
            lowc++;
            if (prev === 1'b0 && dac_sclk === 1'b1) begin
                f = {f[30:0], dac_sdo};
                nb++;
                if ((lowc - (HALF + 1)) % DIV != 0) period_ok = 0;
            end
            prev = dac_sclk;
        end
        chk("R3 bit count", 32'(nb), 32'd32);
        chk("R3 sync low cycles", 32'(lowc), 32'(32 * DIV));
        chk("R5 sclk phase", 32'(period_ok), 32'd1);
        chk("R5 sclk high while idle", 32'(idle_ok), 32'd1);
        chk("R10 busy after frame", 32'(busy), 32'd0);
        chk("R10 done at sync rise", 32'(done), 32'd1);
        if (have_prev) begin
            chk("R9 frame spacing", 32'(fall_cyc - last_fall), 32'(PERIOD));
            chk("R5 gap at least one sclk period", 32'(gap >= DIV), 32'd1);
        end
        @(negedge clk);
        chk("R10 done lasts one cycle", 32'(done), 32'd0);
        last_fall = fall_cyc;
        have_prev = 1;
    endtask

    task automatic t_reset();
        chk("R1 sclk in reset", 32'(dac_sclk), 32'd1);
        chk("R1 sync in reset", 32'(dac_sync_n), 32'd1);
        chk("R1 sdo in reset", 32'(dac_sdo), 32'd0);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sync after reset", 32'(dac_sync_n), 32'd1);
        chk("R1 sclk after reset", 32'(dac_sclk), 32'd1);
    endtask

    task automatic t_setup();
        logic [31:0] f;
        capture(f);
        chk("R2 setup frame", f, 32'h0800_0001);
    endtask

    task automatic t_rotation();
        logic [31:0] f;
        for (int ch = 0; ch < 4; ch++) begin
            capture(f);
            chk("R6 auto frame", f, chan_frame(4'b0011, 4'(ch), smp(ch)));
        end
        sample_in[11:0] = 12'h001;
        capture(f);
        chk("R2 R6 wrap to channel 0, no second setup", f, chan_frame(4'b0011, 4'd0, 12'h001));
    endtask

    task automatic t_latch();
        logic [31:0] f;
        fork
            capture(f);
            begin
                while (dac_sync_n !== 1'b0) @(negedge clk);
                repeat (40) @(negedge clk);
                sample_in[23:12] = 12'h777;
            end
        join
        chk("R7 mid-frame change ignored", f, chan_frame(4'b0011, 4'd1, 12'h123));
    endtask

    task automatic t_manual();
        logic [31:0] f;
        manual_en = 1'b1; manual_sel = 8'h3F;
        capture(f);
        chk("R8 manual all-channel frame", f, chan_frame(4'h3, 4'hF, smp(3)));
        manual_sel = 8'h31;
        capture(f);
        chk("R8 manual single channel", f, chan_frame(4'h3, 4'h1, smp(1)));
        manual_en = 1'b0;
        capture(f);
        chk("R8 auto resumes at channel 2", f, chan_frame(4'b0011, 4'd2, smp(2)));
    endtask

    initial begin
        sample_in = {12'hFFF, 12'h5A5, 12'h123, 12'hABC};
        repeat (5) @(negedge clk);
        t_reset();
        t_setup();
        t_rotation();
        t_latch();
        t_manual();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog run did not complete, actual=timeout expected=end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule